// File: doc/BRIEF.md
# Flash MMU page translator

This block turns a virtual address in the external-flash window into a 24-bit physical flash address. Flash is split into 64 KB pages. A table of page entries says which physical page backs each virtual page, for each CPU and each process ID. Software loads entries through a simple indexed write port. A requester presents a CPU select, a process ID and a 32-bit virtual address on the lookup port. One cycle later the block returns the physical address together with a hit flag, a fault flag for an entry marked invalid, and a separate flag for an address outside the flash window.

Each entry is 9 bits wide. The low 8 bits hold the physical page number. The top bit is an active-low valid marker: the entry is usable only when that bit is 0. The table is laid out in regions. The CPU-0 regions start at index 0 and the CPU-1 regions start at a fixed offset. Within each CPU, the regions are spaced by a fixed stride per process ID. The entry for a lookup is its region base plus the virtual page number.

Top module: `flash_page_xlate`

## Requirements
- R1: The entry index is (cpu ? 2048 : 0) + pid*128 + vpage, where vpage = (vaddr - 0x4040_0000) >> 16. For example, CPU 1, PID 4 and address 0x4044_048C use entry 2564.
- R2: On a hit, rsp_paddr equals {entry[7:0], vaddr[15:0]}.
- R3: If the selected entry has bit 8 set, the response has rsp_fault=1, rsp_hit=0 and rsp_paddr=0.
- R4: After reset, every entry reads as 0x100, so any in-window lookup faults until its entry has been written.
- R5: An address below 0x4040_0000 or at or above 0x4080_0000 gives rsp_range_err=1, rsp_hit=0, rsp_fault=0 and rsp_paddr=0.
- R6: rsp_valid is lk_valid delayed by one cycle. Back-to-back lookups each get their own result. While rsp_valid is 0, every flag and rsp_paddr is 0.
- R7: A write with wr_index of 3072 or above changes no entry.
- R8: A lookup in the same cycle as a write to its own entry returns the old content. The next lookup returns the new content.
- R9: At most one of rsp_hit, rsp_fault and rsp_range_err is 1.
- R10: During and right after reset, all response outputs are 0.
- R11: The two CPUs use separate entries for the same PID and page, so a mapping written for one CPU does not change what the other CPU sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | 12 | Entry index to write |
| wr_data | input | 9 | Entry value: bit 8 invalid, bits 7:0 physical page |
| lk_valid | input | 1 | Lookup request |
| lk_cpu | input | 1 | Requesting CPU (0 or 1) |
| lk_pid | input | 3 | Process ID |
| lk_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response valid, one cycle after lk_valid |
| rsp_hit | output | 1 | Valid mapping found |
| rsp_fault | output | 1 | Entry marked invalid |
| rsp_range_err | output | 1 | Address outside the flash window |
| rsp_paddr | output | 24 | Physical flash address |

## Verification
Lookups use the worked mapping (CPU 1, PID 4, page 4 to page 0x44) and the same page and PID on the other CPU. These two cases check that the CPU term of the index is applied. The lowest and highest pages of the window, combined with the lowest and highest PIDs, test the stride and page terms as well as the offset pass-through at both ends of the window. Addresses one byte below and one byte above the window check the range flag against a fault. Rewriting an entry with its invalid bit set, and writing in the same cycle as a lookup of that entry, separate valid-bit decoding from stale or early reads. Back-to-back lookups and an idle cycle show that each result goes with its own request.

// File: rtl/flash_xlate_pkg.sv
package flash_xlate_pkg;

    localparam int OFFSET_W = 16;
    localparam int PPAGE_W  = 8;
    localparam int ENTRY_W  = PPAGE_W + 1;
    localparam int PADDR_W  = PPAGE_W + OFFSET_W;

    typedef struct packed {
        logic               invalid;
        logic [PPAGE_W-1:0] ppage;
    } entry_t;

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic               fault;
        logic               range_err;
        logic [PADDR_W-1:0] paddr;
    } resp_t;

    localparam entry_t ENTRY_RESET = '{invalid: 1'b1, ppage: '0};

    function automatic logic [PADDR_W-1:0] compose_paddr(
        input entry_t                e,
        input logic [OFFSET_W-1:0]   offset
    );
        return {e.ppage, offset};
    endfunction

endpackage

// File: rtl/flash_xlate_decode.sv
module flash_xlate_decode
    import flash_xlate_pkg::*;
#(
    parameter int          NUM_PID       = 8,
    parameter int          REGION_STRIDE = 128,
    parameter int          APP_BASE      = 2048,
    parameter logic [31:0] WIN_BASE      = 32'h4040_0000,
    parameter int          WIN_PAGES     = 64,
    parameter int          IDX_W         = 12,
    localparam int         PID_W         = $clog2(NUM_PID),
    localparam int         VP_W          = $clog2(WIN_PAGES)
) (
    input  logic                 cpu,
    input  logic [PID_W-1:0]     pid,
    input  logic [31:0]          vaddr,
    output logic                 in_window,
    output logic [IDX_W-1:0]     index,
    output logic [OFFSET_W-1:0]  offset
);

    localparam logic [32:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [32:0] WIN_HI = WIN_LO + (33'(WIN_PAGES) << OFFSET_W);

    logic [31:0]      rel;
    logic [VP_W-1:0]  vpage;
    logic [IDX_W-1:0] cpu_base;
    logic [IDX_W-1:0] pid_base;
    logic             unused_rel_bits;

    always_comb begin
        in_window = ({1'b0, vaddr} >= WIN_LO) && ({1'b0, vaddr} < WIN_HI);
        rel       = vaddr - WIN_BASE;
        vpage     = rel[OFFSET_W +: VP_W];
        offset    = vaddr[OFFSET_W-1:0];
        cpu_base  = cpu ? IDX_W'(APP_BASE) : '0;
        pid_base  = IDX_W'(pid) * IDX_W'(REGION_STRIDE);
        index     = cpu_base + pid_base + IDX_W'(vpage);
    end

    assign unused_rel_bits = ^{rel[31:OFFSET_W+VP_W], rel[OFFSET_W-1:0]};

endmodule

// File: rtl/flash_xlate_table.sv
module flash_xlate_table
    import flash_xlate_pkg::*;
#(
    parameter int DEPTH = 3072,
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  entry_t            wr_entry,
    input  logic [IDX_W-1:0]  rd_index,
    output entry_t            rd_entry
);

    localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

    entry_t           store [DEPTH];
    logic [DEPTH-1:0] loaded;
    logic             wr_ok;

    assign wr_ok = wr_en && ({1'b0, wr_index} < DEPTH_L);

    // Validity tracked separately so reset clears one vector, not the array.
    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= '0;
        end else if (wr_ok) begin
            loaded[wr_index] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_index] <= wr_entry;
        end
    end

    always_comb begin
        if (({1'b0, rd_index} < DEPTH_L) && loaded[rd_index]) begin
            rd_entry = store[rd_index];
        end else begin
            rd_entry = ENTRY_RESET;
        end
    end

endmodule

// File: rtl/flash_page_xlate.sv
module flash_page_xlate
    import flash_xlate_pkg::*;
#(
    parameter int          NUM_PID       = 8,
    parameter int          REGION_STRIDE = 128,
    parameter int          APP_BASE      = 2048,
    parameter logic [31:0] WIN_BASE      = 32'h4040_0000,
    parameter int          WIN_PAGES     = 64,
    localparam int         DEPTH         = APP_BASE + NUM_PID * REGION_STRIDE,
    localparam int         IDX_W         = $clog2(DEPTH),
    localparam int         PID_W         = $clog2(NUM_PID)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic [ENTRY_W-1:0]   wr_data,
    input  logic                 lk_valid,
    input  logic                 lk_cpu,
    input  logic [PID_W-1:0]     lk_pid,
    input  logic [31:0]          lk_vaddr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_fault,
    output logic                 rsp_range_err,
    output logic [PADDR_W-1:0]   rsp_paddr
);

    logic                in_window;
    logic [IDX_W-1:0]    lk_index;
    logic [OFFSET_W-1:0] lk_offset;
    entry_t              lk_entry;
    resp_t               resp_d;
    resp_t               resp_q;

    flash_xlate_decode #(
        .NUM_PID      (NUM_PID),
        .REGION_STRIDE(REGION_STRIDE),
        .APP_BASE     (APP_BASE),
        .WIN_BASE     (WIN_BASE),
        .WIN_PAGES    (WIN_PAGES),
        .IDX_W        (IDX_W)
    ) u_decode (
        .cpu      (lk_cpu),
        .pid      (lk_pid),
        .vaddr    (lk_vaddr),
        .in_window(in_window),
        .index    (lk_index),
        .offset   (lk_offset)
    );

    flash_xlate_table #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_index(wr_index),
        .wr_entry(entry_t'(wr_data)),
        .rd_index(lk_index),
        .rd_entry(lk_entry)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.valid = lk_valid;
        if (lk_valid) begin
            if (!in_window) begin
                resp_d.range_err = 1'b1;
            end else if (lk_entry.invalid) begin
                resp_d.fault = 1'b1;
            end else begin
                resp_d.hit   = 1'b1;
                resp_d.paddr = compose_paddr(lk_entry, lk_offset);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid     = resp_q.valid;
    assign rsp_hit       = resp_q.hit;
    assign rsp_fault     = resp_q.fault;
    assign rsp_range_err = resp_q.range_err;
    assign rsp_paddr     = resp_q.paddr;

endmodule

// File: rtl/flash_page_xlate_chk.sv
module flash_page_xlate_chk #(
    parameter logic [31:0] WIN_BASE  = 32'h4040_0000,
    parameter int          WIN_PAGES = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic        rsp_range_err,
    input logic [23:0] rsp_paddr
);

    localparam logic [32:0] LO = {1'b0, WIN_BASE};
    localparam logic [32:0] HI = LO + (33'(WIN_PAGES) << 16);

    logic outside;
    assign outside = ({1'b0, lk_vaddr} < LO) || ({1'b0, lk_vaddr} >= HI);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_fault && !rsp_range_err && rsp_paddr == '0));

    p_onehot_flags_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_fault, rsp_range_err}));

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_hit || rsp_paddr[15:0] == $past(lk_vaddr[15:0])));

    p_range_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && outside) |=> (rsp_range_err && rsp_paddr == '0));

    p_fault_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_paddr == '0);

endmodule

bind flash_page_xlate flash_page_xlate_chk #(
    .WIN_BASE (WIN_BASE),
    .WIN_PAGES(WIN_PAGES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_fault    (rsp_fault),
    .rsp_range_err(rsp_range_err),
    .rsp_paddr    (rsp_paddr)
);

// File: tb/flash_page_xlate_tb.sv
`timescale 1ns/1ps
module flash_page_xlate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [11:0] wr_index;
    logic [8:0]  wr_data;
    logic        lk_valid;
    logic        lk_cpu;
    logic [2:0]  lk_pid;
    logic [31:0] lk_vaddr;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_range_err;
    logic [23:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_page_xlate u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_index(wr_index), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_cpu(lk_cpu), .lk_pid(lk_pid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_range_err(rsp_range_err), .rsp_paddr(rsp_paddr)
    );

    function automatic int idx_of(input bit cpu, input int pid, input logic [31:0] va);
        return (cpu ? 2048 : 0) + pid * 128 + int'((va - 32'h4040_0000) >> 16);
    endfunction

    task automatic check_resp(input string req, input bit v, input bit h, input bit f,
                              input bit r, input logic [23:0] pa);
        checks++;
        if (rsp_valid !== v || rsp_hit !== h || rsp_fault !== f ||
            rsp_range_err !== r || rsp_paddr !== pa) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b f=%0b r=%0b pa=%06h, expected v=%0b h=%0b f=%0b r=%0b pa=%06h",
                     req, rsp_valid, rsp_hit, rsp_fault, rsp_range_err, rsp_paddr, v, h, f, r, pa);
        end
    endtask

    task automatic write_entry(input int idx, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 12'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input bit cpu, input logic [2:0] pid, input logic [31:0] va);
        @(negedge clk);
        lk_valid = 1'b1; lk_cpu = cpu; lk_pid = pid; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        check_resp("R10 reset", 0, 0, 0, 0, 24'h0);
        lookup(1, 4, 32'h4044_048C);
        check_resp("R4 unwritten entry faults", 1, 0, 1, 0, 24'h0);
    endtask

    task automatic t_worked_mapping;
        if (idx_of(1, 4, 32'h4044_048C) != 2564) begin
            checks++; errors++;
            $display("FAIL R1: index %0d expected 2564", idx_of(1, 4, 32'h4044_048C));
        end
        write_entry(2564, 9'h044);
        lookup(1, 4, 32'h4044_048C);
        check_resp("R1 R2 app pid4 page4", 1, 1, 0, 0, 24'h44_048C);
    endtask

    task automatic t_cpu_split;
        lookup(0, 4, 32'h4044_048C);
        check_resp("R11 other cpu unmapped", 1, 0, 1, 0, 24'h0);
        write_entry(idx_of(0, 4, 32'h4044_048C), 9'h0A5);
        lookup(0, 4, 32'h4044_048C);
        check_resp("R11 cpu0 own mapping", 1, 1, 0, 0, 24'hA5_048C);
        lookup(1, 4, 32'h4044_048C);
        check_resp("R11 cpu1 unchanged", 1, 1, 0, 0, 24'h44_048C);
    endtask

    task automatic t_window_edges;
        write_entry(idx_of(0, 7, 32'h407F_FFFF), 9'h0FF);
        lookup(0, 7, 32'h407F_FFFF);
        check_resp("R1 R2 top page pid7", 1, 1, 0, 0, 24'hFF_FFFF);
        write_entry(idx_of(1, 0, 32'h4040_0000), 9'h001);
        lookup(1, 0, 32'h4040_0000);
        check_resp("R1 R2 bottom page pid0", 1, 1, 0, 0, 24'h01_0000);
    endtask

    task automatic t_invalid_bit;
        write_entry(2564, 9'h144);
        lookup(1, 4, 32'h4044_048C);
        check_resp("R3 invalid bit set", 1, 0, 1, 0, 24'h0);
    endtask

    task automatic t_out_of_window;
        lookup(1, 0, 32'h403F_FFFF);
        check_resp("R5 below window", 1, 0, 0, 1, 24'h0);
        lookup(0, 7, 32'h4080_0000);
        check_resp("R5 above window", 1, 0, 0, 1, 24'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        lk_valid = 1'b1; lk_cpu = 1'b0; lk_pid = 3'd4; lk_vaddr = 32'h4044_1234;
        @(negedge clk);
        check_resp("R6 first of pair", 1, 1, 0, 0, 24'hA5_1234);
        lk_cpu = 1'b1; lk_pid = 3'd0; lk_vaddr = 32'h4040_00AA;
        @(negedge clk);
        check_resp("R6 second of pair", 1, 1, 0, 0, 24'h01_00AA);
        lk_valid = 1'b0;
        @(negedge clk);
        check_resp("R6 idle after pair", 0, 0, 0, 0, 24'h0);
    endtask

    task automatic t_bad_index;
        write_entry(3072, 9'h011);
        write_entry(4095, 9'h022);
        lookup(0, 0, 32'h4040_0000);
        check_resp("R7 entry 0 untouched", 1, 0, 1, 0, 24'h0);
        lookup(1, 7, 32'h407F_0000);
        check_resp("R7 last entry untouched", 1, 0, 1, 0, 24'h0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_index = 12'd2564; wr_data = 9'h033;
        lk_valid = 1'b1; lk_cpu = 1'b1; lk_pid = 3'd4; lk_vaddr = 32'h4044_048C;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check_resp("R8 old content", 1, 0, 1, 0, 24'h0);
        lookup(1, 4, 32'h4044_048C);
        check_resp("R8 new content", 1, 1, 0, 0, 24'h33_048C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_index = '0; wr_data = '0;
        lk_valid = 1'b0; lk_cpu = 1'b0; lk_pid = '0; lk_vaddr = '0;
        repeat (3) @(negedge clk);
        check_resp("R10 in reset", 0, 0, 0, 0, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_worked_mapping();
        t_cpu_split();
        t_window_edges();
        t_invalid_bit();
        t_out_of_window();
        t_latency();
        t_bad_index();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule